// File: doc/BRIEF.md
# Inter-Core Mailbox Controller

This block lets a small group of processor cores pass short messages to one another and signal each other by interrupt. It holds a configurable number of mailboxes. Each mailbox has its own 64-byte window of registers on a 32-bit read/write bus. A core claims an idle mailbox by writing its own one-hot core bit to the owner register. While it holds the claim it sets the target cores, an interrupt mask, the completion mode and a set of payload words. It then fires the mailbox by writing its own bit to the fire register, and every target core that is not masked receives an interrupt.

A receiving core finishes a message by writing the completion register. In automatic completion the mailbox goes straight back to idle. In manual completion it moves to an acknowledged state and interrupts the owner instead. The owner then releases the mailbox by writing its bit to the owner register a second time. Every core has a raw and a masked status word with one bit per mailbox, and one interrupt line that is the OR of its masked bits.

All writes pass through a write-protect gate. The gate is closed after reset and opens when a key value is written to the gate register. Reads are never blocked.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the gate is closed (gate register at 0xA00 reads 1), every mailbox is idle (mode word reads 0x10), `rdata` is 0 and every `irq_o` bit is low.
- R2: While the gate is closed, every write other than one to 0xA00 is ignored. Writing 0x1ACCE551 to 0xA00 opens the gate, so 0xA00 reads 0. Writing any other value to 0xA00 closes the gate again. Reads work with the gate open or closed.
- R3: Mailbox n sits at byte offset n*64, and its owner register is at window offset 0x00. The owner register reads 0 while the mailbox is idle. A write of a nonzero core mask (bits 4:0 for five cores) to the owner register of an idle mailbox records that mask as owner and claims the mailbox. A write of zero leaves the mailbox idle.
- R4: A write to the owner register while the mailbox is claimed or fired leaves the recorded owner unchanged.
- R5: The target mask (0x04), interrupt mask (0x14, low five bits stored), mode (0x10, bit 0) and payload words (0x20 + 4*i) are written only while the mailbox is claimed. In any other state a write to them leaves the stored value unchanged.
- R6: A write to the fire register (0x1C) fires a claimed mailbox only when the written value equals the owner mask. While the mailbox is fired, the target-status register (0x0C) reads the target mask; in every other state it reads 0.
- R7: With mode bit 0 set, a write to the completion register (0x08), or to its alias (0x18), while the mailbox is fired returns it to idle and clears the owner.
- R8: With mode bit 0 clear, the same completion write moves the mailbox to the acknowledged state, which interrupts the owner cores. A later owner write equal to the owner mask releases the mailbox to idle. An owner write with any other value leaves it acknowledged.
- R9: The mode word reads bit 4 = idle, bit 5 = claimed, bit 6 = fired, bit 7 = acknowledged, and bit 0 = automatic completion.
- R10: Bit n of the raw status word of core c (0x804 + c*8) is set when mailbox n targets core c: as a target while fired, or as an owner while acknowledged. The masked status word (0x800 + c*8) is the raw word with bits cleared where mailbox n masks core c.
- R11: `irq_o[c]` is the OR of core c's masked status word and is registered. It changes on the clock edge after the edge that changed a mailbox's state.
- R12: `rdata` is loaded on the edge that samples `rd_en` and holds otherwise. A read that shares a cycle with a write to the same address returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe; loads `rdata` at the edge |
| addr | input | 12 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | N_CORE | One interrupt line per core |

## Verification
A read and a write can land in the same clock cycle. Both use the single address bus, so the read sees the same register that the write changes. The bench raises `rd_en` and `wr_en` together on the owner register of an idle mailbox and expects the pre-claim value of zero. A following read must then return the new owner, and the mode word must show the claimed state. A second overlap is timing rather than bus sharing: the state change lands on one edge and the interrupt line follows on the next. The bench therefore samples `irq_o` both right after the firing and completion writes, when it must still hold its old value, and one cycle later, when it must hold the new one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_CLAIM = 2'd1,
    CH_SENT  = 2'd2,
    CH_ACK   = 2'd3
  } ch_state_t;

  // word offsets inside a 64-byte mailbox window (byte offset / 4)
  localparam logic [3:0] W_OWNER  = 4'd0;
  localparam logic [3:0] W_TARGET = 4'd1;
  localparam logic [3:0] W_DONE   = 4'd2;
  localparam logic [3:0] W_TSTAT  = 4'd3;
  localparam logic [3:0] W_MODE   = 4'd4;
  localparam logic [3:0] W_MASK   = 4'd5;
  localparam logic [3:0] W_DONE2  = 4'd6;
  localparam logic [3:0] W_FIRE   = 4'd7;

  localparam int MODE_AUTO_BIT  = 0;
  localparam int MODE_IDLE_BIT  = 4;
  localparam int MODE_CLAIM_BIT = 5;
  localparam int MODE_SENT_BIT  = 6;
  localparam int MODE_ACK_BIT   = 7;

  localparam logic [11:0] GATE_ADDR  = 12'hA00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int N_CORE = 5,
  parameter int N_DATA = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [3:0]        woff_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [3:0]        rd_woff_i,
  output logic [DW-1:0]     rd_word_o,
  output ch_state_t         state_o,
  output logic [N_CORE-1:0] raw_o,
  output logic [N_CORE-1:0] mask_o
);
  localparam int DIW = (N_DATA > 1) ? $clog2(N_DATA) : 1;

  ch_state_t         state_q;
  logic [N_CORE-1:0] owner_q, target_q, mask_q;
  logic              auto_q;
  logic [DW-1:0]     data_q [N_DATA];

  logic [N_CORE-1:0] wcores;
  logic              is_done;
  assign wcores  = wdata_i[N_CORE-1:0];
  assign is_done = (woff_i == W_DONE) || (woff_i == W_DONE2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CH_IDLE;
      owner_q  <= '0;
      target_q <= '0;
      mask_q   <= '0;
      auto_q   <= 1'b0;
    end else if (wr_i) begin
      if (woff_i == W_OWNER) begin
        if (state_q == CH_IDLE && |wcores) begin
          owner_q <= wcores;
          state_q <= CH_CLAIM;
        end else if (state_q == CH_ACK && wcores == owner_q) begin
          owner_q  <= '0;
          target_q <= '0;
          state_q  <= CH_IDLE;
        end
      end else if (is_done) begin
        if (state_q == CH_SENT) begin
          if (auto_q) begin
            owner_q  <= '0;
            target_q <= '0;
            state_q  <= CH_IDLE;
          end else begin
            state_q <= CH_ACK;
          end
        end
      end else if (state_q == CH_CLAIM) begin
        case (woff_i)
          W_TARGET: target_q <= wcores;
          W_MASK:   mask_q   <= wcores;
          W_MODE:   auto_q   <= wdata_i[MODE_AUTO_BIT];
          W_FIRE:   if (wcores == owner_q) state_q <= CH_SENT;
          default:  ;
        endcase
      end
    end
  end

  // payload storage, no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_i && state_q == CH_CLAIM && woff_i[3] &&
        ({1'b0, woff_i[2:0]} < 4'(N_DATA)))
      data_q[woff_i[DIW-1:0]] <= wdata_i;
  end

  always_comb begin
    rd_word_o = '0;
    case (rd_woff_i)
      W_OWNER:  rd_word_o = DW'(owner_q);
      W_TARGET: rd_word_o = DW'(target_q);
      W_TSTAT:  rd_word_o = (state_q == CH_SENT) ? DW'(target_q) : '0;
      W_MASK:   rd_word_o = DW'(mask_q);
      W_MODE: begin
        rd_word_o[MODE_AUTO_BIT]  = auto_q;
        rd_word_o[MODE_IDLE_BIT]  = (state_q == CH_IDLE);
        rd_word_o[MODE_CLAIM_BIT] = (state_q == CH_CLAIM);
        rd_word_o[MODE_SENT_BIT]  = (state_q == CH_SENT);
        rd_word_o[MODE_ACK_BIT]   = (state_q == CH_ACK);
      end
      default:
        if (rd_woff_i[3] && ({1'b0, rd_woff_i[2:0]} < 4'(N_DATA)))
          rd_word_o = data_q[rd_woff_i[DIW-1:0]];
    endcase
  end

  assign state_o = state_q;
  assign mask_o  = mask_q;
  assign raw_o   = (state_q == CH_SENT) ? target_q :
                   (state_q == CH_ACK)  ? owner_q  : '0;

  // R4
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && woff_i == W_OWNER && (state_q == CH_CLAIM || state_q == CH_SENT))
      |=> $stable(owner_q));

  // R6
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CH_IDLE) |=> (state_q == CH_IDLE || state_q == CH_CLAIM));

  // R7
  auto_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && is_done && state_q == CH_SENT && auto_q) |=> (state_q == CH_IDLE));

  // R8
  manual_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && is_done && state_q == CH_SENT && !auto_q) |=> (state_q == CH_ACK));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int N_BOX  = 4,
  parameter int N_CORE = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_BOX-1:0][N_CORE-1:0]  raw_i,
  input  logic [N_BOX-1:0][N_CORE-1:0]  mask_i,
  output logic [N_CORE-1:0][N_BOX-1:0]  raw_stat_o,
  output logic [N_CORE-1:0][N_BOX-1:0]  msk_stat_o,
  output logic [N_CORE-1:0]             irq_o
);
  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar b = 0; b < N_BOX; b++) begin : g_box
      assign raw_stat_o[c][b] = raw_i[b][c];
      assign msk_stat_o[c][b] = raw_i[b][c] & ~mask_i[b][c];
    end

    always_ff @(posedge clk) begin
      if (rst) irq_o[c] <= 1'b0;
      else     irq_o[c] <= |msk_stat_o[c];
    end

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> $past(|raw_stat_o[c]));
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int N_BOX  = 4,
  parameter int N_CORE = 5,
  parameter int N_DATA = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [11:0]       addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [N_CORE-1:0] irq_o
);
  localparam int BIW = (N_BOX > 1) ? $clog2(N_BOX) : 1;
  localparam int CIW = (N_CORE > 1) ? $clog2(N_CORE) : 1;

  logic gated_q;
  logic [DW-1:0] rdata_q, rdata_d;

  logic [4:0] box_sel, core_sel;
  logic       box_hit, stat_hit, is_gate, wr_ok;
  assign box_sel  = addr[10:6];
  assign core_sel = addr[7:3];
  assign is_gate  = (addr == GATE_ADDR);
  assign box_hit  = !addr[11] && (box_sel < 5'(N_BOX));
  assign stat_hit = (addr[11:8] == 4'h8) && (core_sel < 5'(N_CORE));
  assign wr_ok    = wr_en && !gated_q && !is_gate;

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[1:0];

  logic [DW-1:0]                      box_rd [N_BOX];
  logic [N_BOX-1:0][N_CORE-1:0]       box_raw, box_mask;
  logic [2*N_BOX-1:0]                 st_flat;
  logic [N_CORE-1:0][N_BOX-1:0]       raw_stat, msk_stat;

  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    ch_state_t st_b;
    mbox_channel #(.N_CORE(N_CORE), .N_DATA(N_DATA), .DW(DW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_i      (wr_ok && !addr[11] && box_sel == 5'(b)),
      .woff_i    (addr[5:2]),
      .wdata_i   (wdata),
      .rd_woff_i (addr[5:2]),
      .rd_word_o (box_rd[b]),
      .state_o   (st_b),
      .raw_o     (box_raw[b]),
      .mask_o    (box_mask[b])
    );
    assign st_flat[2*b +: 2] = st_b;
  end

  mbox_irq #(.N_BOX(N_BOX), .N_CORE(N_CORE)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .raw_i      (box_raw),
    .mask_i     (box_mask),
    .raw_stat_o (raw_stat),
    .msk_stat_o (msk_stat),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                  gated_q <= 1'b1;
    else if (wr_en && is_gate) gated_q <= (wdata != UNLOCK_KEY);
  end

  always_comb begin
    rdata_d = '0;
    if (is_gate)
      rdata_d = DW'(gated_q);
    else if (box_hit)
      rdata_d = box_rd[box_sel[BIW-1:0]];
    else if (stat_hit)
      rdata_d = addr[2] ? DW'(raw_stat[core_sel[CIW-1:0]])
                        : DW'(msk_stat[core_sel[CIW-1:0]]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

  // R2
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    (gated_q && wr_en && !is_gate) |=> $stable(st_flat));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/mbox_ctrl_test.sv
module mbox_ctrl_test;
  localparam int N_CORE = 5;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam int NV = 62;
  // {write(1)/read-check(0), addr, data, expected, requirement number}
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 12'hA00, 32'h0, 32'h1, 8'd1},          // R1 gate closed
    {1'b0, 12'h010, 32'h0, 32'h10, 8'd1},         // R1 idle
    {1'b1, 12'h000, 32'h1, 32'h0, 8'd2},          // R2 write while gated
    {1'b0, 12'h010, 32'h0, 32'h10, 8'd2},
    {1'b0, 12'h000, 32'h0, 32'h0, 8'd2},
    {1'b1, 12'hA00, KEY, 32'h0, 8'd2},
    {1'b0, 12'hA00, 32'h0, 32'h0, 8'd2},          // R2 open
    {1'b1, 12'h000, 32'h0, 32'h0, 8'd3},          // R3 zero claim
    {1'b0, 12'h010, 32'h0, 32'h10, 8'd3},
    {1'b1, 12'h000, 32'h1, 32'h0, 8'd3},
    {1'b0, 12'h000, 32'h0, 32'h1, 8'd3},          // R3 owner recorded
    {1'b0, 12'h010, 32'h0, 32'h20, 8'd9},         // R9 claimed
    {1'b1, 12'h000, 32'h2, 32'h0, 8'd4},
    {1'b0, 12'h000, 32'h0, 32'h1, 8'd4},          // R4
    {1'b1, 12'h004, 32'h10, 32'h0, 8'd5},
    {1'b1, 12'h014, 32'hFFFFFFEE, 32'h0, 8'd5},
    {1'b0, 12'h014, 32'h0, 32'h0E, 8'd5},         // R5 mask
    {1'b1, 12'h010, 32'h1, 32'h0, 8'd5},
    {1'b1, 12'h020, 32'hDEADBEEF, 32'h0, 8'd5},
    {1'b1, 12'h024, 32'h12345678, 32'h0, 8'd5},
    {1'b0, 12'h020, 32'h0, 32'hDEADBEEF, 8'd5},   // R5 payload
    {1'b0, 12'h024, 32'h0, 32'h12345678, 8'd5},
    {1'b0, 12'h00C, 32'h0, 32'h0, 8'd6},          // R6 not fired
    {1'b1, 12'h01C, 32'h1, 32'h0, 8'd6},
    {1'b0, 12'h010, 32'h0, 32'h41, 8'd9},         // R9 fired + auto
    {1'b0, 12'h00C, 32'h0, 32'h10, 8'd6},         // R6 target status
    {1'b0, 12'h824, 32'h0, 32'h1, 8'd10},         // R10 raw core4
    {1'b0, 12'h820, 32'h0, 32'h1, 8'd10},
    {1'b0, 12'h804, 32'h0, 32'h0, 8'd10},
    {1'b1, 12'h000, 32'h4, 32'h0, 8'd4},
    {1'b0, 12'h000, 32'h0, 32'h1, 8'd4},          // R4 fired
    {1'b1, 12'h020, 32'h0, 32'h0, 8'd5},
    {1'b0, 12'h020, 32'h0, 32'hDEADBEEF, 8'd5},   // R5 locked payload
    {1'b1, 12'h008, 32'h1, 32'h0, 8'd7},
    {1'b0, 12'h010, 32'h0, 32'h11, 8'd7},         // R7 back to idle
    {1'b0, 12'h000, 32'h0, 32'h0, 8'd7},
    {1'b0, 12'h824, 32'h0, 32'h0, 8'd7},
    {1'b1, 12'h040, 32'h4, 32'h0, 8'd8},
    {1'b1, 12'h044, 32'h2, 32'h0, 8'd8},
    {1'b1, 12'h054, 32'h2, 32'h0, 8'd8},
    {1'b1, 12'h050, 32'h0, 32'h0, 8'd8},
    {1'b1, 12'h05C, 32'h1, 32'h0, 8'd6},
    {1'b0, 12'h050, 32'h0, 32'h20, 8'd6},         // R6 wrong fire value
    {1'b1, 12'h05C, 32'h4, 32'h0, 8'd6},
    {1'b0, 12'h050, 32'h0, 32'h40, 8'd9},
    {1'b0, 12'h80C, 32'h0, 32'h2, 8'd10},         // R10 raw core1
    {1'b0, 12'h808, 32'h0, 32'h0, 8'd10},         // R10 masked core1
    {1'b1, 12'h048, 32'h2, 32'h0, 8'd8},
    {1'b0, 12'h050, 32'h0, 32'h80, 8'd8},         // R8 acknowledged
    {1'b0, 12'h814, 32'h0, 32'h2, 8'd8},
    {1'b0, 12'h810, 32'h0, 32'h2, 8'd8},
    {1'b0, 12'h80C, 32'h0, 32'h0, 8'd8},
    {1'b1, 12'h040, 32'h1, 32'h0, 8'd8},
    {1'b0, 12'h050, 32'h0, 32'h80, 8'd8},         // R8 wrong release
    {1'b1, 12'h040, 32'h4, 32'h0, 8'd8},
    {1'b0, 12'h050, 32'h0, 32'h10, 8'd8},         // R8 released
    {1'b0, 12'h814, 32'h0, 32'h0, 8'd8},
    {1'b1, 12'hA00, 32'h5, 32'h0, 8'd2},
    {1'b0, 12'hA00, 32'h0, 32'h1, 8'd2},          // R2 closed again
    {1'b1, 12'h040, 32'h1, 32'h0, 8'd2},
    {1'b0, 12'h040, 32'h0, 32'h0, 8'd2},
    {1'b1, 12'hA00, KEY, 32'h0, 8'd2}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N_CORE-1:0] irq_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbox_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata, e, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata, 32'h0, "R1 rdata after reset");
    check(32'(irq_o), 32'h0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) wr(VEC[i][83:72], VEC[i][71:40]);
      else rd(VEC[i][83:72], VEC[i][39:8], $sformatf("R%0d vector %0d", VEC[i][7:0], i));
    end

    // R11: auto mailbox 0 targeting core 4, interrupt one edge after state
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h10);
    wr(12'h01C, 32'h1);
    check(32'(irq_o), 32'h0, "R11 irq lags fire");
    @(negedge clk);
    check(32'(irq_o), 32'h10, "R11 irq core4 raised");
    wr(12'h008, 32'h1);
    check(32'(irq_o), 32'h10, "R11 irq lags completion");
    @(negedge clk);
    check(32'(irq_o), 32'h0, "R11 irq core4 dropped");

    // R11/R8: masked target gets no interrupt, owner gets one on ack
    wr(12'h040, 32'h4);
    wr(12'h044, 32'h2);
    wr(12'h05C, 32'h4);
    @(negedge clk);
    check(32'(irq_o), 32'h0, "R11 masked target silent");
    wr(12'h048, 32'h2);
    @(negedge clk);
    check(32'(irq_o), 32'h04, "R8 owner interrupted on ack");
    wr(12'h040, 32'h4);
    @(negedge clk);
    check(32'(irq_o), 32'h0, "R8 owner irq cleared on release");

    // R12: read and write together on the owner register
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 12'h000; wdata = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rdata, 32'h0, "R12 concurrent read sees old owner");
    addr = 12'h010;
    @(negedge clk);
    check(rdata, 32'h0, "R12 rdata holds without rd_en");
    rd(12'h000, 32'h1, "R12 owner after write");
    rd(12'h010, 32'h21, "R12 mode claimed");

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(rdata, 32'h0, "R1 rdata after second reset");
    rd(12'hA00, 32'h1, "R1 gate closed after reset");
    rd(12'h010, 32'h10, "R1 mailbox idle after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule